// File: doc/BRIEF.md
# Split Nibble Register File

This block is a small register file of eight 4-bit registers that can be reached two ways at once. Eight narrow read ports and eight narrow write ports each pick registers with a per-register select vector instead of a binary address. One wide read port and one wide write port see all eight registers together as one 32-bit word. A typical use is a file of condition-code fields: single fields are read and updated one at a time, and the whole set is saved or restored in one access.

Reads are combinational. A read of a register that is being written in the same cycle returns the data being written, for the narrow ports and for every nibble of the wide port. Writes take effect at the rising clock edge. When several writers hit one register in the same cycle, a fixed priority picks exactly one of them.

Top module: `nrf_split_regfile`

## Requirements
- R1: The wide word maps register i to bits [4i+3:4i], so register 0 is the least significant nibble.
- R2: A narrow write port stores its 4-bit data at the clock edge into every register whose bit is set in its select vector (bit i selects register i).
- R3: A narrow read port returns the bitwise OR of the values of every register whose select bit is set; an all-zero select returns 0.
- R4: When the wide write enable is high, all eight registers take their nibble of the 32-bit write word at the clock edge.
- R5: When the wide read enable is high, the wide read port returns all eight registers; when it is low it returns 0.
- R6: A narrow read of a register written in the same cycle returns the winning write data, not the stored value.
- R7: The wide read applies write-through nibble by nibble, taking each nibble from the write that wins that register in the current cycle.
- R8: A narrow write to a register overrides a wide write to the same register in the same cycle; other nibbles of the wide write still land.
- R9: Among several narrow ports writing one register in the same cycle, the lowest-numbered port wins.
- R10: A synchronous active-high reset clears all registers to 0 and overrides any write in that cycle.
- R11: A register with no write in a cycle keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| nrd_sel | input | 8x8 | Per narrow read port, register select vector |
| nrd_data | output | 8x4 | Per narrow read port, OR of selected forwarded values |
| nwr_sel | input | 8x8 | Per narrow write port, register select vector |
| nwr_data | input | 8x4 | Per narrow write port, write data |
| wrd_en | input | 1 | Wide read enable |
| wrd_data | output | 32 | Wide read word |
| wwr_en | input | 1 | Wide write enable |
| wwr_data | input | 32 | Wide write word |

## Verification
The hardest situation to reach is a single register contested by the wide writer and several narrow writers in one cycle, since the winner is only visible through forwarding in that cycle and through the stored value afterwards. The bench builds that case on every register in turn with many different subsets of contending narrow ports, reads the forwarded value through another narrow port and the wide port in the same cycle, and reads the stored value back the next cycle. Per-port sweeps over every port and register pair cover the select mapping and the nibble placement in the wide word.

// File: rtl/nrf_pkg.sv
`timescale 1ns/1ps
package nrf_pkg;
    parameter int NRF_REGS  = 8;
    parameter int NRF_NIB   = 4;
    parameter int NRF_PORTS = 8;
    localparam int NRF_WIDE = NRF_REGS * NRF_NIB;

    typedef logic [NRF_NIB-1:0]  nib_t;
    typedef logic [NRF_REGS-1:0] rsel_t;
    typedef logic [NRF_WIDE-1:0] word_t;

    // Resolved write for one register in one cycle
    typedef struct packed {
        logic vld;
        nib_t data;
    } wr_slot_t;

    function automatic nib_t nib_of(word_t w, int idx);
        return w[idx*NRF_NIB +: NRF_NIB];
    endfunction
endpackage

// File: rtl/nrf_write_arb.sv
`timescale 1ns/1ps
// Picks one writer per register: lowest narrow port first, wide port last.
module nrf_write_arb
    import nrf_pkg::*;
(
    input  rsel_t [NRF_PORTS-1:0]     nsel,
    input  nib_t  [NRF_PORTS-1:0]     ndata,
    input  logic                      wen,
    input  word_t                     wdata,
    output wr_slot_t [NRF_REGS-1:0]   slot
);
    always_comb begin
        for (int r = 0; r < NRF_REGS; r++) begin
            slot[r].vld  = wen;
            slot[r].data = nib_of(wdata, r);
            // descending scan so the lowest port is applied last
            for (int p = NRF_PORTS-1; p >= 0; p--) begin
                if (nsel[p][r]) begin
                    slot[r].vld  = 1'b1;
                    slot[r].data = ndata[p];
                end
            end
        end
    end
endmodule

// File: rtl/nrf_store.sv
`timescale 1ns/1ps
// Storage plus write-through view of each register.
module nrf_store
    import nrf_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  wr_slot_t [NRF_REGS-1:0]   slot,
    output nib_t     [NRF_REGS-1:0]   fwd
);
    nib_t [NRF_REGS-1:0] q;

    always_ff @(posedge clk) begin
        for (int r = 0; r < NRF_REGS; r++) begin
            if (rst)               q[r] <= '0;
            else if (slot[r].vld)  q[r] <= slot[r].data;
        end
    end

    always_comb begin
        for (int r = 0; r < NRF_REGS; r++)
            fwd[r] = slot[r].vld ? slot[r].data : q[r];
    end
endmodule

// File: rtl/nrf_read_port.sv
`timescale 1ns/1ps
// One narrow read port: OR of all selected forwarded registers.
module nrf_read_port
    import nrf_pkg::*;
(
    input  rsel_t                    sel,
    input  nib_t [NRF_REGS-1:0]      fwd,
    output nib_t                     data
);
    always_comb begin
        data = '0;
        for (int r = 0; r < NRF_REGS; r++)
            if (sel[r]) data = data | fwd[r];
    end
endmodule

// File: rtl/nrf_split_regfile.sv
`timescale 1ns/1ps
module nrf_split_regfile
    import nrf_pkg::*;
(
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic [NRF_PORTS-1:0][NRF_REGS-1:0]      nrd_sel,
    output logic [NRF_PORTS-1:0][NRF_NIB-1:0]       nrd_data,
    input  logic [NRF_PORTS-1:0][NRF_REGS-1:0]      nwr_sel,
    input  logic [NRF_PORTS-1:0][NRF_NIB-1:0]       nwr_data,
    input  logic                                    wrd_en,
    output logic [NRF_WIDE-1:0]                     wrd_data,
    input  logic                                    wwr_en,
    input  logic [NRF_WIDE-1:0]                     wwr_data
);
    wr_slot_t [NRF_REGS-1:0] slot;
    nib_t     [NRF_REGS-1:0] fwd;

    nrf_write_arb u_arb (
        .nsel  (nwr_sel),
        .ndata (nwr_data),
        .wen   (wwr_en),
        .wdata (wwr_data),
        .slot  (slot)
    );

    nrf_store u_store (
        .clk  (clk),
        .rst  (rst),
        .slot (slot),
        .fwd  (fwd)
    );

    for (genvar p = 0; p < NRF_PORTS; p++) begin : g_rd
        nrf_read_port u_rd (
            .sel  (nrd_sel[p]),
            .fwd  (fwd),
            .data (nrd_data[p])
        );
    end

    always_comb begin
        for (int r = 0; r < NRF_REGS; r++)
            wrd_data[r*NRF_NIB +: NRF_NIB] = wrd_en ? fwd[r] : '0;
    end
endmodule

// File: rtl/nrf_checker.sv
`timescale 1ns/1ps
module nrf_checker
    import nrf_pkg::*;
(
    input logic                                    clk,
    input logic                                    rst,
    input logic [NRF_PORTS-1:0][NRF_REGS-1:0]      nrd_sel,
    input logic [NRF_PORTS-1:0][NRF_NIB-1:0]       nrd_data,
    input logic [NRF_PORTS-1:0][NRF_REGS-1:0]      nwr_sel,
    input logic [NRF_PORTS-1:0][NRF_NIB-1:0]       nwr_data,
    input logic                                    wrd_en,
    input logic [NRF_WIDE-1:0]                     wrd_data,
    input logic                                    wwr_en,
    input logic [NRF_WIDE-1:0]                     wwr_data
);
    logic no_wr;
    assign no_wr = !wwr_en && (nwr_sel == '0);

    for (genvar p = 0; p < NRF_PORTS; p++) begin : g_p
        assert_zero_sel_R3: assert property (@(posedge clk) disable iff (rst)
            (nrd_sel[p] == '0) |-> (nrd_data[p] == '0));
        // port 0 always wins the register it writes
        assert_port0_fwd_R9: assert property (@(posedge clk) disable iff (rst)
            ($onehot(nwr_sel[0]) && nrd_sel[p] == nwr_sel[0]) |-> (nrd_data[p] == nwr_data[0]));
    end

    assert_wide_off_R5: assert property (@(posedge clk) disable iff (rst)
        !wrd_en |-> (wrd_data == '0));
    assert_wide_fwd_R7: assert property (@(posedge clk) disable iff (rst)
        (wwr_en && nwr_sel == '0 && wrd_en) |-> (wrd_data == wwr_data));
    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && no_wr && wrd_en) |-> (wrd_data == '0));
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && no_wr && wrd_en) && no_wr && wrd_en) |-> $stable(wrd_data));
endmodule

bind nrf_split_regfile nrf_checker u_chk (.*);

// File: tb/tb_nrf_split_regfile.sv
`timescale 1ns/1ps
module tb_nrf_split_regfile;
    logic                 clk = 1'b0;
    logic                 rst;
    logic [7:0][7:0]      nrd_sel, nwr_sel;
    logic [7:0][3:0]      nrd_data, nwr_data;
    logic                 wrd_en, wwr_en;
    logic [31:0]          wrd_data, wwr_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0] mdl [8];
    logic [3:0] efw [8];
    logic       ewr [8];

    always #10 clk = ~clk;

    nrf_split_regfile dut (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        nrd_sel = '0; nwr_sel = '0; nwr_data = '0;
        wrd_en = 1'b1; wwr_en = 1'b0; wwr_data = '0;
    endtask

    // inputs set after a falling edge; check, take the rising edge, update model
    task automatic step(string tag);
        logic [3:0]  e;
        logic [31:0] w;
        #2;
        for (int r = 0; r < 8; r++) begin
            efw[r] = mdl[r]; ewr[r] = 1'b0;
            if (wwr_en) begin efw[r] = wwr_data[r*4 +: 4]; ewr[r] = 1'b1; end
            for (int p = 7; p >= 0; p--)
                if (nwr_sel[p][r]) begin efw[r] = nwr_data[p]; ewr[r] = 1'b1; end
        end
        for (int q = 0; q < 8; q++) begin
            e = '0;
            for (int r = 0; r < 8; r++) if (nrd_sel[q][r]) e = e | efw[r];
            chk(tag, {28'd0, nrd_data[q]}, {28'd0, e});
        end
        w = '0;
        for (int r = 0; r < 8; r++) w[r*4 +: 4] = efw[r];
        chk(tag, wrd_data, wrd_en ? w : 32'd0);
        @(posedge clk);
        for (int r = 0; r < 8; r++)
            if (rst) mdl[r] = '0; else if (ewr[r]) mdl[r] = efw[r];
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int r = 0; r < 8; r++) mdl[r] = 'x;
        idle();
        rst = 1'b1; wwr_en = 1'b1; wwr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        @(posedge clk);
        for (int r = 0; r < 8; r++) mdl[r] = '0;
        @(negedge clk);
        nwr_sel[2] = 8'hFF; nwr_data[2] = 4'h9;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0; idle();
        step("R10 reset clears and overrides writes");

        // narrow port x register sweep
        for (int p = 0; p < 8; p++) begin
            for (int r = 0; r < 8; r++) begin
                idle();
                nwr_sel[p] = 8'(1 << r); nwr_data[p] = 4'((p*3 + r + 1) & 15);
                nrd_sel[(p+1)%8] = 8'(1 << r);
                step("R2 R6 narrow write with same-cycle read");
                idle();
                nrd_sel[p] = 8'(1 << r);
                step("R2 R11 narrow stored value");
            end
        end

        // wide write patterns, read back nibble by nibble
        for (int k = 0; k < 6; k++) begin
            idle();
            wwr_en = 1'b1; wwr_data = 32'h7654_3210 ^ (32'h1111_1111 * k) ^ (k << 5);
            nrd_sel[k] = 8'(1 << k);
            step("R4 R7 wide write forwarded");
            idle();
            for (int q = 0; q < 8; q++) nrd_sel[q] = 8'(1 << q);
            step("R1 R4 nibble mapping");
        end

        // wide read disabled
        idle(); wrd_en = 1'b0; nrd_sel[0] = 8'h01;
        step("R5 wide read disabled");
        idle(); wrd_en = 1'b0; wwr_en = 1'b1; wwr_data = 32'hDEAD_BEEF;
        step("R5 R4 wide read disabled during wide write");

        // multi-hot OR reads
        for (int k = 0; k < 16; k++) begin
            idle();
            for (int q = 0; q < 8; q++) nrd_sel[q] = 8'((k * 37 + q * 91 + 5) & 255);
            nrd_sel[k % 8] = '0;
            step("R3 OR of selected registers");
        end

        // contested registers
        for (int r = 0; r < 8; r++) begin
            for (int m = 0; m < 256; m += 17) begin
                idle();
                wwr_en = 1'b1; wwr_data = 32'hA5C3_96E1 ^ (m * 32'h0101_0101);
                for (int p = 0; p < 8; p++)
                    if (m[p]) begin nwr_sel[p] = 8'(1 << r); nwr_data[p] = 4'(p + 8); end
                nrd_sel[(r+4)%8] = 8'(1 << r);
                step("R8 R9 contested register forwarded");
                idle();
                nrd_sel[0] = 8'(1 << r);
                step("R8 R9 contested register stored");
            end
        end

        // multi-bit write select
        idle(); nwr_sel[5] = 8'hA5; nwr_data[5] = 4'hC; nwr_sel[6] = 8'h5A; nwr_data[6] = 4'h3;
        step("R2 multi-bit write select");
        for (int k = 0; k < 4; k++) begin
            idle(); nrd_sel[k] = 8'(1 << k);
            step("R11 hold without writes");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule